// File: doc/BRIEF.md
# Power-Loss Flags and Resume-State Selector

This block notes when power is lost and picks the sleep state that the system enters when main power comes back. It watches two asynchronous inputs. One is a main-power-good level. The other is an active-low reset for the resume well. Each input passes through a flop synchroniser, and a falling edge on either one sets its own sticky flag. Software clears a flag with a one-cycle write-one-to-clear pulse.

On the first failure edge the block reads the sleep state that was in effect and a single stay-off configuration bit, and looks up the state to enter on power return. It holds that result, marked valid, until the power-return strobe arrives.

The block also keeps the wake-event enable bit and the wake-event status bit. Both are forced to zero for as long as the synchronised resume-well reset is low. A wake request is raised only when both bits are set and no power-failure flag is pending, so a wake cannot come from the enable bit across a power loss.

Top module: `pwr_fail_resume`

## Requirements
- R1: A falling edge on `pgood_i` sets `pgood_fail_o`. The flag reads 0 at the second rising clock edge after the input falls and reads 1 from the third edge on (two synchroniser flops, then the flag register).
- R2: A falling edge on `rsm_rst_n_i` sets `pwr_fail_o` with the same timing as R1.
- R3: A pulse on `flag_clr_i` clears the matching flag at the next clock edge. Bit 0 clears `pgood_fail_o` and bit 1 clears `pwr_fail_o`.
- R4: A flag stays set until it is cleared. When a new failure edge and a clear pulse reach the same flag in the same cycle, the flag stays set.
- R5: While the synchronised resume-well reset is low, `wake_en_o` and `wake_sts_o` are 0 from the next clock edge on, and writes and events are ignored.
- R6: `wake_req_o` is 1 only when `wake_en_o` and `wake_sts_o` are both 1 and `pwr_fail_o` is 0.
- R7: Sleep states are encoded S0=000, S1=001, S3=011, S4=100, S5=101. The resume state depends on the stay-off bit. With the bit at 0 it is S0. With the bit at 1 it is S4 when the state at failure was S4, and S5 for any other state.
- R8: The resume state is captured on the clock edge where the first failure edge's flag is set, and `resume_valid_o` rises on that edge. Both then hold steady, whatever the inputs do and whatever further failures occur, until `pwr_return_i`. On that strobe `resume_valid_o` drops at the next edge and `resume_state_o` keeps its value.
- R9: After reset both flags are 0, both wake bits are 0, `resume_valid_o` is 0 and `resume_state_o` is S0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgood_i | input | 1 | Asynchronous main-power-good level |
| rsm_rst_n_i | input | 1 | Asynchronous active-low resume-well reset |
| sleep_state_i | input | 3 | Sleep state now in effect |
| stay_off_i | input | 1 | Stay-off configuration bit for power return |
| flag_clr_i | input | 2 | Write-one-to-clear pulses (bit 0 power-good flag, bit 1 power flag) |
| pwr_return_i | input | 1 | Power-return strobe; releases the held resume state |
| wake_en_wr_i | input | 1 | Write strobe for the wake enable bit |
| wake_en_d_i | input | 1 | Value to write to the wake enable bit |
| wake_evt_i | input | 1 | Wake event; sets the wake status bit |
| wake_sts_clr_i | input | 1 | Clears the wake status bit |
| pgood_fail_o | output | 1 | Sticky power-good failure flag |
| pwr_fail_o | output | 1 | Sticky resume-well power failure flag |
| resume_state_o | output | 3 | State to enter on power return |
| resume_valid_o | output | 1 | Resume state is held and waiting for power return |
| wake_en_o | output | 1 | Wake enable bit |
| wake_sts_o | output | 1 | Wake status bit |
| wake_req_o | output | 1 | Wake request |

## Verification
The assertions assume that `pgood_i` and `rsm_rst_n_i` are high while `rst_n` is low. The synchronisers reset to the power-good level, so a low input during reset would show up as a failure edge once reset ends. They also assume that `sleep_state_i` and `stay_off_i` stay steady across the synchroniser latency around a failure. The stimulus holds both failure inputs high through reset. It draws the sleep state only from the five legal codes, and it changes the state and the stay-off bit only while no failure is in flight. Randomised values that are meant to have no effect are applied only after the capture edge has passed.

// File: rtl/pfr_pkg.sv
// Package: shared types and the resume-state lookup for the power-loss block.
// Assumes 3-bit sleep-state codes; any code other than S4 counts as a non-hibernate state.
package pfr_pkg;
    localparam int STATE_W = 3;
    localparam int NUM_SRC = 2;   // index 0: power good, index 1: resume-well reset

    typedef enum logic [STATE_W-1:0] {
        SLP_S0 = 3'b000,
        SLP_S1 = 3'b001,
        SLP_S3 = 3'b011,
        SLP_S4 = 3'b100,
        SLP_S5 = 3'b101
    } slp_state_e;

    // Picks the state to enter on power return; hibernate survives a stay-off setting.
    function automatic logic [STATE_W-1:0] resume_pick(input logic [STATE_W-1:0] at_fail,
                                                       input logic stay_off);
        if (!stay_off)
            return SLP_S0;
        else if (at_fail == SLP_S4)
            return SLP_S4;
        else
            return SLP_S5;
    endfunction
endpackage

// File: rtl/pfr_sync.sv
// Flop-chain synchroniser with falling-edge detection.
// Assumes STAGES >= 2 and that the input sits at RST_VAL while rst_n is low.
module pfr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dsync,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Move the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Keep the last synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= chain[STAGES-1];
    end

    assign dsync = chain[STAGES-1];
    assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/pfr_flags.sv
// Bank of sticky flags: set by an event, cleared by a write-one-to-clear pulse.
// Assumes set and clr are synchronous one-cycle pulses; set beats clear.
module pfr_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // One sticky bit; a set in the same cycle as a clear keeps the bit high.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[g] <= 1'b0;
            else if (set[g]) flag[g] <= 1'b1;
            else if (clr[g]) flag[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/pfr_resume.sv
// Captures the resume state at the first failure edge and holds it until power returns.
// Assumes sleep_state and stay_off are steady when the failure edge is detected.
module pfr_resume
    import pfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fail_edge,
    input  logic [STATE_W-1:0] sleep_state,
    input  logic               stay_off,
    input  logic               pwr_return,
    output logic [STATE_W-1:0] resume_state,
    output logic               resume_valid
);
    logic take;

    // Capture when nothing is held, or when the strobe frees the slot in the same cycle.
    assign take = fail_edge & (~resume_valid | pwr_return);

    // Hold the table result, and its valid mark, until the power-return strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_state <= SLP_S0;
            resume_valid <= 1'b0;
        end else if (take) begin
            resume_state <= resume_pick(sleep_state, stay_off);
            resume_valid <= 1'b1;
        end else if (pwr_return) begin
            resume_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pfr_wake.sv
// Wake enable and status bits, wiped while the resume-well reset is active.
// Assumes rsm_active is already synchronised; a pending power failure masks the request.
module pfr_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic rsm_active,
    input  logic en_wr,
    input  logic en_d,
    input  logic evt,
    input  logic sts_clr,
    input  logic pwr_failed,
    output logic wake_en,
    output logic wake_sts,
    output logic wake_req
);
    // Enable bit: written by software, zeroed during the resume-well reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rsm_active) wake_en <= 1'b0;
        else if (en_wr)           wake_en <= en_d;
    end

    // Status bit: set by an event, cleared by software, zeroed during the resume-well reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rsm_active) wake_sts <= 1'b0;
        else if (evt)             wake_sts <= 1'b1;
        else if (sts_clr)         wake_sts <= 1'b0;
    end

    assign wake_req = wake_en & wake_sts & ~pwr_failed;
endmodule

// File: rtl/pwr_fail_resume.sv
// Top level: synchronises both power inputs, keeps the failure flags, picks the resume
// state and looks after the wake bits. Assumes both power inputs are high during rst_n.
module pwr_fail_resume
    import pfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pgood_i,
    input  logic               rsm_rst_n_i,
    input  logic [STATE_W-1:0] sleep_state_i,
    input  logic               stay_off_i,
    input  logic [NUM_SRC-1:0] flag_clr_i,
    input  logic               pwr_return_i,
    input  logic               wake_en_wr_i,
    input  logic               wake_en_d_i,
    input  logic               wake_evt_i,
    input  logic               wake_sts_clr_i,
    output logic               pgood_fail_o,
    output logic               pwr_fail_o,
    output logic [STATE_W-1:0] resume_state_o,
    output logic               resume_valid_o,
    output logic               wake_en_o,
    output logic               wake_sts_o,
    output logic               wake_req_o
);
    logic [NUM_SRC-1:0] raw_w;
    logic [NUM_SRC-1:0] sync_w;
    logic [NUM_SRC-1:0] fall_w;
    logic [NUM_SRC-1:0] flag_w;

    assign raw_w = {rsm_rst_n_i, pgood_i};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        pfr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_w[g]),
            .dsync (sync_w[g]),
            .fall  (fall_w[g])
        );
    end

    pfr_flags #(.N(NUM_SRC)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fall_w),
        .clr   (flag_clr_i),
        .flag  (flag_w)
    );

    pfr_resume u_resume (
        .clk          (clk),
        .rst_n        (rst_n),
        .fail_edge    (|fall_w),
        .sleep_state  (sleep_state_i),
        .stay_off     (stay_off_i),
        .pwr_return   (pwr_return_i),
        .resume_state (resume_state_o),
        .resume_valid (resume_valid_o)
    );

    pfr_wake u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsm_active (~sync_w[1]),
        .en_wr      (wake_en_wr_i),
        .en_d       (wake_en_d_i),
        .evt        (wake_evt_i),
        .sts_clr    (wake_sts_clr_i),
        .pwr_failed (flag_w[1]),
        .wake_en    (wake_en_o),
        .wake_sts   (wake_sts_o),
        .wake_req   (wake_req_o)
    );

    assign pgood_fail_o = flag_w[0];
    assign pwr_fail_o   = flag_w[1];
endmodule

// File: rtl/pfr_checker.sv
// Checker for pwr_fail_resume, bound to every instance of the top.
// Assumes the power inputs are high during reset and the state inputs are steady at capture.
module pfr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fall,
    input logic [1:0] sync,
    input logic [1:0] flag_clr,
    input logic       pwr_return,
    input logic       pgood_fail,
    input logic       pwr_fail,
    input logic [2:0] resume_state,
    input logic       resume_valid,
    input logic       wake_en,
    input logic       wake_sts
);
    assert_pgood_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall[0] |=> pgood_fail);

    assert_pwr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall[1] |=> pwr_fail);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood_fail && flag_clr[0] && !fall[0]) |=> !pgood_fail);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && !flag_clr[1]) |=> pwr_fail);

    assert_wake_wipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sync[1] |=> (!wake_en && !wake_sts));

    assert_legal_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_valid) |-> (resume_state == 3'b000 || resume_state == 3'b100 ||
                                 resume_state == 3'b101));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_valid && !pwr_return) |=> (resume_valid && $stable(resume_state)));
endmodule

bind pwr_fail_resume pfr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fall         (fall_w),
    .sync         (sync_w),
    .flag_clr     (flag_clr_i),
    .pwr_return   (pwr_return_i),
    .pgood_fail   (pgood_fail_o),
    .pwr_fail     (pwr_fail_o),
    .resume_state (resume_state_o),
    .resume_valid (resume_valid_o),
    .wake_en      (wake_en_o),
    .wake_sts     (wake_sts_o)
);

// File: tb/pwr_fail_resume_tb.sv
module pwr_fail_resume_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pgood_i = 1'b1;
    logic       rsm_rst_n_i = 1'b1;
    logic [2:0] sleep_state_i = 3'b000;
    logic       stay_off_i = 1'b0;
    logic [1:0] flag_clr_i = 2'b00;
    logic       pwr_return_i = 1'b0;
    logic       wake_en_wr_i = 1'b0;
    logic       wake_en_d_i = 1'b0;
    logic       wake_evt_i = 1'b0;
    logic       wake_sts_clr_i = 1'b0;
    logic       pgood_fail_o, pwr_fail_o, resume_valid_o;
    logic       wake_en_o, wake_sts_o, wake_req_o;
    logic [2:0] resume_state_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_fail_resume u_dut (
        .clk(clk), .rst_n(rst_n), .pgood_i(pgood_i), .rsm_rst_n_i(rsm_rst_n_i),
        .sleep_state_i(sleep_state_i), .stay_off_i(stay_off_i), .flag_clr_i(flag_clr_i),
        .pwr_return_i(pwr_return_i), .wake_en_wr_i(wake_en_wr_i), .wake_en_d_i(wake_en_d_i),
        .wake_evt_i(wake_evt_i), .wake_sts_clr_i(wake_sts_clr_i),
        .pgood_fail_o(pgood_fail_o), .pwr_fail_o(pwr_fail_o),
        .resume_state_o(resume_state_o), .resume_valid_o(resume_valid_o),
        .wake_en_o(wake_en_o), .wake_sts_o(wake_sts_o), .wake_req_o(wake_req_o)
    );

    // Expected resume state from the R7 table.
    function automatic logic [2:0] exp_resume(input logic [2:0] st, input logic off);
        if (!off) return 3'b000;
        return (st == 3'b100) ? 3'b100 : 3'b101;
    endfunction

    function automatic logic [2:0] legal_state(input int unsigned k);
        case (k % 5)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b011;
            3: return 3'b100;
            default: return 3'b101;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One rising edge passes; returns at the following falling edge.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0] st;
        logic       off;
        logic [2:0] held;
        void'($urandom(32'd4242));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R9 reset state
        check("R9 flags", {pgood_fail_o, pwr_fail_o}, 0);
        check("R9 valid", resume_valid_o, 0);
        check("R9 state", resume_state_o, 3'b000);
        check("R9 wake", {wake_en_o, wake_sts_o}, 0);

        // Random failures, each followed by hold, sticky, clear and power return.
        for (int i = 0; i < 40; i++) begin
            int unsigned kind;
            kind = $urandom % 2;
            st   = legal_state($urandom);
            off  = 1'(($urandom % 2));
            if (i < 2) begin st = 3'b100; off = 1'b1; end   // directed hibernate case
            sleep_state_i = st;
            stay_off_i    = off;
            if (kind == 0) pgood_i = 1'b0; else rsm_rst_n_i = 1'b0;
            step(2);
            check(kind == 0 ? "R1 early" : "R2 early", kind == 0 ? pgood_fail_o : pwr_fail_o, 0);
            step(1);
            check(kind == 0 ? "R1 set" : "R2 set", kind == 0 ? pgood_fail_o : pwr_fail_o, 1);
            check("R8 valid", resume_valid_o, 1);
            check("R7 table", resume_state_o, exp_resume(st, off));
            held = resume_state_o;
            // Inputs that must not disturb the held state.
            sleep_state_i = legal_state($urandom);
            stay_off_i    = ~off;
            pgood_i = 1'b1; rsm_rst_n_i = 1'b1;
            step(4);
            if (kind == 0) rsm_rst_n_i = 1'b0; else pgood_i = 1'b0;
            step(4);
            check("R8 hold", {resume_valid_o, resume_state_o}, {1'b1, held});
            check("R4 sticky", {pgood_fail_o, pwr_fail_o}, 2'b11);
            pgood_i = 1'b1; rsm_rst_n_i = 1'b1;
            step(4);
            flag_clr_i = 2'b11;
            step(1);
            flag_clr_i = 2'b00;
            check("R3 clear", {pgood_fail_o, pwr_fail_o}, 0);
            pwr_return_i = 1'b1;
            step(1);
            pwr_return_i = 1'b0;
            check("R8 release", {resume_valid_o, resume_state_o}, {1'b0, held});
        end

        // R4 set wins over a clear in the same cycle.
        pgood_i = 1'b0;
        step(3);
        pgood_i = 1'b1;
        step(4);
        pgood_i = 1'b0;
        step(2);
        flag_clr_i = 2'b01;
        step(1);
        flag_clr_i = 2'b00;
        check("R4 set wins", pgood_fail_o, 1);
        pgood_i = 1'b1;
        flag_clr_i = 2'b01;
        step(1);
        flag_clr_i = 2'b00;
        check("R3 clear bit0", pgood_fail_o, 0);
        pwr_return_i = 1'b1;
        step(1);
        pwr_return_i = 1'b0;

        // R6 wake request when no power failure is pending.
        wake_en_wr_i = 1'b1; wake_en_d_i = 1'b1; wake_evt_i = 1'b1;
        step(1);
        wake_en_wr_i = 1'b0; wake_evt_i = 1'b0;
        check("R6 request", {wake_en_o, wake_sts_o, wake_req_o}, 3'b111);
        // R5 resume-well reset wipes both bits and ignores writes.
        rsm_rst_n_i = 1'b0;
        step(3);
        check("R5 wiped", {wake_en_o, wake_sts_o}, 0);
        wake_en_wr_i = 1'b1; wake_evt_i = 1'b1;
        step(1);
        wake_en_wr_i = 1'b0; wake_evt_i = 1'b0;
        check("R5 ignored", {wake_en_o, wake_sts_o}, 0);
        rsm_rst_n_i = 1'b1;
        step(3);
        // R6 masked while the power flag is set.
        wake_en_wr_i = 1'b1; wake_evt_i = 1'b1;
        step(1);
        wake_en_wr_i = 1'b0; wake_evt_i = 1'b0;
        check("R6 masked", {wake_en_o, wake_sts_o, pwr_fail_o, wake_req_o}, 4'b1110);
        flag_clr_i = 2'b10;
        step(1);
        flag_clr_i = 2'b00;
        check("R6 unmasked", wake_req_o, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule